// File: doc/BRIEF.md
# Pluggable Module Low-Speed Controller

This block is the module-side control logic for the slow sideband pins of a pluggable transceiver. It samples three host-driven pins: an active-low select, an active-low reset request and a low-power request. It also serves a small management register port that stands in for the serial management slave. From these inputs it drives an active-low interrupt, a not-ready status, a gate that lets the serial slave answer, and the resolved power mode with its class.

A reset request counts only when the reset pin stays low for longer than a minimum number of clock cycles. Once a request qualifies, every user setting returns to its default and the not-ready status rises. The initialisation timer starts when the pin is released. When the timer expires, not-ready clears and the interrupt is posted. The same sequence runs by itself after power-up.

The host clears the interrupt by reading the flag register. The power mode comes from the pin unless software takes over through an override bit.

Top module: `pm_lowspeed_ctrl`

## Requirements
- R1: The answer gate `twi_en_o` equals the inverse of `sel_n_i` three clock edges after that pin changes. While the gate is low, register writes are ignored, reads return 0x00, and a read of the flag register does not clear the flag.
- R2: The reset pin qualifies a reset only when it is low for more than `RST_MIN` consecutive cycles. A low pulse of `RST_MIN` cycles or fewer leaves the settings, the flag and the not-ready status unchanged.
- R3: When a reset qualifies, the control register returns to 0x00, the completion flag clears and not-ready rises. The pin-driven default then gives low power while the pin is high.
- R4: Initialisation starts when the reset pin is released. Not-ready stays high for `T_INIT` cycles of the timer. When it falls, the completion flag is set and `int_n_o` goes low on the same clock edge.
- R5: After the synchronous power-up reset, not-ready is high and `int_n_o` is high. Initialisation then runs without any activity on the reset pin and ends with the interrupt posted.
- R6: A read of the flag register (address 3) while the gate is high returns bit 0 = completion flag. The read clears the flag, so `int_n_o` returns high and a second read returns 0x00.
- R7: The control register sits at address 93. Bit 0 is the override, bit 1 is the software low-power bit and bits 3:2 are the power class. With the override at 0, `low_pwr_o` follows the low-power pin (1 = low power). With the override at 1, `low_pwr_o` follows bit 1. Reading address 93 returns the stored low nibble with bits 7:4 at 0.
- R8: `pwr_class_o` shows the class field while in high power and reads 0 while in low power.
- R9: The status register (address 2) returns the not-ready status in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sel_n_i | input | 1 | Active-low module select pin |
| rst_pin_n_i | input | 1 | Active-low reset request pin |
| lpm_i | input | 1 | Low-power request pin, high = low power |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid one cycle after the read strobe |
| twi_en_o | output | 1 | Lets the serial slave acknowledge and answer |
| int_n_o | output | 1 | Active-low interrupt |
| dnr_o | output | 1 | Not-ready status |
| low_pwr_o | output | 1 | Resolved power mode, 1 = low power |
| pwr_class_o | output | 2 | Active power class, 0 in low power |

## Verification
A reset qualifier stuck in the wrong state shows up within a few cycles. Either not-ready rises after a short pulse, or it stays low after a long one. A miscounted initialisation timer moves the falling edge of not-ready and the interrupt by that many cycles, and the bench brackets that edge from both sides. A fault in the flag or the control register shows up at the next read through the register port. A power mode resolved from the wrong source shows on `low_pwr_o` and `pwr_class_o` within the synchroniser delay of a pin change.

// File: rtl/pm_lowspeed_pkg.sv
package pm_lowspeed_pkg;
  typedef enum logic [1:0] {
    RQ_IDLE  = 2'd0,
    RQ_ARMED = 2'd1,
    RQ_INIT  = 2'd2
  } rq_state_t;

  typedef struct packed {
    logic [1:0] cls;
    logic       pset;
    logic       povr;
  } pwr_ctrl_t;

  localparam int CTRL_W = 4;
endpackage

// File: rtl/pm_pin_sync.sv
module pm_pin_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] IDLE  = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE[b]}};
        else     chain <= {chain[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pm_rst_qual.sv
module pm_rst_qual
  import pm_lowspeed_pkg::*;
#(
  parameter int RST_MIN = 4,
  parameter int T_INIT  = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  output logic busy_o,
  output logic clr_o,
  output logic done_o
);
  localparam int CW = $clog2(RST_MIN + 2);
  localparam int TW = $clog2(T_INIT + 1);

  rq_state_t       state;
  logic [CW-1:0]   lowcnt;
  logic [TW-1:0]   tmr;

  assign clr_o  = (state == RQ_IDLE) && !pin_s && (lowcnt == CW'(RST_MIN));
  assign done_o = (state == RQ_INIT) && (tmr == TW'(T_INIT - 1));
  assign busy_o = (state != RQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RQ_INIT;
      lowcnt <= '0;
      tmr    <= '0;
    end else begin
      case (state)
        RQ_IDLE: begin
          if (pin_s) lowcnt <= '0;
          else if (clr_o) begin
            state  <= RQ_ARMED;
            lowcnt <= '0;
          end else lowcnt <= lowcnt + 1'b1;
        end
        RQ_ARMED: begin
          if (pin_s) begin
            state <= RQ_INIT;
            tmr   <= '0;
          end
        end
        RQ_INIT: begin
          if (done_o) state <= RQ_IDLE;
          else        tmr   <= tmr + 1'b1;
        end
        default: state <= RQ_IDLE;
      endcase
    end
  end

  p_timer_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (state == RQ_INIT) |-> (tmr < TW'(T_INIT)));
  p_arm_needs_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(!pin_s));
  p_init_on_release_r4: assert property (@(posedge clk) disable iff (rst)
    (state == RQ_ARMED && pin_s) |=> (state == RQ_INIT));
  p_powerup_busy_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busy_o);
endmodule

// File: rtl/pm_mgmt_regs.sv
module pm_mgmt_regs
  import pm_lowspeed_pkg::*;
#(
  parameter int          AW          = 8,
  parameter int          DW          = 8,
  parameter logic [AW-1:0] ADDR_STATUS = 8'd2,
  parameter logic [AW-1:0] ADDR_FLAG   = 8'd3,
  parameter logic [AW-1:0] ADDR_CTRL   = 8'd93
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic          clr,
  input  logic          done,
  output pwr_ctrl_t     ctrl_o,
  output logic          flag_o,
  output logic [DW-1:0] rdata_o
);
  logic acc_wr, acc_rd;
  assign acc_wr = en && wr;
  assign acc_rd = en && rd;

  always_ff @(posedge clk) begin
    if (rst || clr) ctrl_o <= '0;
    else if (acc_wr && addr == ADDR_CTRL) ctrl_o <= pwr_ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                         flag_o <= 1'b0;
    else if (done)                          flag_o <= 1'b1;
    else if (acc_rd && addr == ADDR_FLAG)   flag_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else if (acc_rd) begin
      case (addr)
        ADDR_STATUS: rdata_o <= DW'(busy);
        ADDR_FLAG:   rdata_o <= DW'(flag_o);
        ADDR_CTRL:   rdata_o <= DW'(ctrl_o);
        default:     rdata_o <= '0;
      endcase
    end else rdata_o <= '0;
  end

  p_flag_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!en && !done && !clr) |=> $stable(flag_o));
  p_desel_rdata_r1: assert property (@(posedge clk) disable iff (rst)
    (rd && !en) |=> (rdata_o == '0));
  p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(ctrl_o));
endmodule

// File: rtl/pm_pwr_arb.sv
module pm_pwr_arb
  import pm_lowspeed_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lpm_s,
  input  pwr_ctrl_t  ctrl,
  output logic       low_pwr_o,
  output logic [1:0] cls_o
);
  logic low_nx;
  assign low_nx = ctrl.povr ? ctrl.pset : lpm_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_pwr_o <= 1'b1;
      cls_o     <= 2'd0;
    end else begin
      low_pwr_o <= low_nx;
      cls_o     <= low_nx ? 2'd0 : ctrl.cls;
    end
  end

  p_pin_rule_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.povr) |=> (low_pwr_o == $past(lpm_s)));
  p_sw_rule_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.povr) |=> (low_pwr_o == $past(ctrl.pset)));
  p_class_zero_r8: assert property (@(posedge clk) disable iff (rst)
    low_pwr_o |-> (cls_o == 2'd0));
endmodule

// File: rtl/pm_lowspeed_ctrl.sv
module pm_lowspeed_ctrl
  import pm_lowspeed_pkg::*;
#(
  parameter int RST_MIN     = 4,
  parameter int T_INIT      = 20,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int ADDR_STATUS = 2,
  parameter int ADDR_FLAG   = 3,
  parameter int ADDR_CTRL   = 93
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_n_i,
  input  logic          rst_pin_n_i,
  input  logic          lpm_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          twi_en_o,
  output logic          int_n_o,
  output logic          dnr_o,
  output logic          low_pwr_o,
  output logic [1:0]    pwr_class_o
);
  logic [2:0] pins_s;
  logic       sel_s, rstp_s, lpm_s;
  logic       busy, clr, done, flag;
  pwr_ctrl_t  ctrl;

  pm_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(3'b111)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({lpm_i, rst_pin_n_i, sel_n_i}),
    .q_o(pins_s)
  );
  assign sel_s  = pins_s[0];
  assign rstp_s = pins_s[1];
  assign lpm_s  = pins_s[2];

  always_ff @(posedge clk) begin
    if (rst) twi_en_o <= 1'b0;
    else     twi_en_o <= !sel_s;
  end

  pm_rst_qual #(.RST_MIN(RST_MIN), .T_INIT(T_INIT)) u_qual (
    .clk(clk), .rst(rst), .pin_s(rstp_s),
    .busy_o(busy), .clr_o(clr), .done_o(done)
  );

  pm_mgmt_regs #(
    .AW(AW), .DW(DW),
    .ADDR_STATUS(AW'(ADDR_STATUS)), .ADDR_FLAG(AW'(ADDR_FLAG)), .ADDR_CTRL(AW'(ADDR_CTRL))
  ) u_regs (
    .clk(clk), .rst(rst), .en(twi_en_o), .wr(reg_wr_i), .rd(reg_rd_i),
    .addr(reg_addr_i), .wdata(reg_wdata_i),
    .busy(busy), .clr(clr), .done(done),
    .ctrl_o(ctrl), .flag_o(flag), .rdata_o(reg_rdata_o)
  );

  pm_pwr_arb u_pwr (
    .clk(clk), .rst(rst), .lpm_s(lpm_s), .ctrl(ctrl),
    .low_pwr_o(low_pwr_o), .cls_o(pwr_class_o)
  );

  assign dnr_o   = busy;
  assign int_n_o = !flag;

  p_int_on_done_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(dnr_o) |-> !int_n_o);
  p_no_int_busy_r3: assert property (@(posedge clk) disable iff (rst)
    dnr_o |-> int_n_o);
  p_gate_follows_r1: assert property (@(posedge clk) disable iff (rst)
    twi_en_o |-> $past(!sel_s));
endmodule

// File: tb/sim_pm_lowspeed_ctrl.sv
module sim_pm_lowspeed_ctrl;
  localparam int RST_MIN = 4;
  localparam int T_INIT  = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_n = 1'b1, rpin_n = 1'b1, lpm = 1'b1;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       en, int_n, dnr, lowp;
  logic [1:0] cls;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { string req; logic [7:0] exp; } sb_item_t;
  sb_item_t sbq[$];
  logic rd_d = 1'b0;

  always #10 clk = ~clk;

  pm_lowspeed_ctrl #(.RST_MIN(RST_MIN), .T_INIT(T_INIT)) u0 (
    .clk(clk), .rst(rst), .sel_n_i(sel_n), .rst_pin_n_i(rpin_n), .lpm_i(lpm),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .twi_en_o(en), .int_n_o(int_n), .dnr_o(dnr),
    .low_pwr_o(lowp), .pwr_class_o(cls)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the expected read data one cycle after each read strobe
  always @(posedge clk) rd_d <= rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (sbq.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL scoreboard: got %h expected nothing queued", rdata);
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        chk(it.req, rdata, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_read(logic [7:0] a, logic [7:0] exp, string req);
    sb_item_t it;
    it.req = req; it.exp = exp;
    sbq.push_back(it);
    addr = a; rd = 1'b1;
    tick(1);
    rd = 1'b0;
    tick(1);
  endtask

  task automatic reg_write(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick(1);
    wr = 1'b0;
  endtask

  task automatic pulse_rst(int width);
    rpin_n = 1'b0;
    tick(width);
    rpin_n = 1'b1;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R5 dnr after power-up", {7'd0, dnr}, 8'd1);
    chk("R5 int_n idle after power-up", {7'd0, int_n}, 8'd1);
    chk("R3 default low power", {7'd0, lowp}, 8'd1);
    chk("R1 gate off while deselected", {7'd0, en}, 8'd0);
    tick(T_INIT + 8);
    chk("R5 dnr cleared after init", {7'd0, dnr}, 8'd0);
    chk("R5 interrupt posted", {7'd0, int_n}, 8'd0);

    sel_n = 1'b0;
    tick(5);
    chk("R1 gate on when selected", {7'd0, en}, 8'd1);
    reg_read(8'd2, 8'h00, "R9 status ready");
    reg_read(8'd3, 8'h01, "R6 flag set");
    chk("R6 int_n released by read", {7'd0, int_n}, 8'd1);
    reg_read(8'd3, 8'h00, "R6 flag cleared");

    reg_write(8'd93, 8'h0C);
    tick(4);
    chk("R7 pin high gives low power", {7'd0, lowp}, 8'd1);
    chk("R8 class hidden in low power", {6'd0, cls}, 8'd0);
    lpm = 1'b0;
    tick(5);
    chk("R7 pin low gives high power", {7'd0, lowp}, 8'd0);
    chk("R8 class shown in high power", {6'd0, cls}, 8'd3);
    reg_write(8'd93, 8'h03);
    tick(3);
    chk("R7 override set forces low power", {7'd0, lowp}, 8'd1);
    lpm = 1'b1;
    reg_write(8'd93, 8'h09);
    tick(5);
    chk("R7 override clear bit gives high power", {7'd0, lowp}, 8'd0);
    chk("R8 class 2", {6'd0, cls}, 8'd2);
    reg_read(8'd93, 8'h09, "R7 ctrl readback");

    // short pulse at the limit is ignored
    pulse_rst(RST_MIN);
    tick(10);
    chk("R2 short pulse no dnr", {7'd0, dnr}, 8'd0);
    chk("R2 short pulse keeps mode", {7'd0, lowp}, 8'd0);
    reg_read(8'd93, 8'h09, "R2 short pulse keeps ctrl");

    // pulse one cycle longer qualifies
    pulse_rst(RST_MIN + 1);
    tick(3);
    chk("R3 dnr after qualified pulse", {7'd0, dnr}, 8'd1);
    reg_read(8'd93, 8'h00, "R3 ctrl defaulted");
    reg_read(8'd2, 8'h01, "R9 status busy");
    chk("R3 pin default low power", {7'd0, lowp}, 8'd1);
    tick(8);
    chk("R4 dnr held during init", {7'd0, dnr}, 8'd1);
    chk("R4 no interrupt during init", {7'd0, int_n}, 8'd1);
    tick(15);
    chk("R4 dnr cleared after init", {7'd0, dnr}, 8'd0);
    chk("R4 interrupt after init", {7'd0, int_n}, 8'd0);
    reg_read(8'd3, 8'h01, "R4 flag after init");

    // long hold: init only starts on release
    rpin_n = 1'b0;
    tick(T_INIT + 20);
    chk("R4 dnr held while pin low", {7'd0, dnr}, 8'd1);
    rpin_n = 1'b1;
    tick(T_INIT - 2);
    chk("R4 init timed from release", {7'd0, dnr}, 8'd1);
    tick(10);
    chk("R4 done after release plus init", {7'd0, dnr}, 8'd0);

    // deselected accesses have no effect
    sel_n = 1'b1;
    tick(5);
    chk("R1 gate off after deselect", {7'd0, en}, 8'd0);
    reg_write(8'd93, 8'h03);
    reg_read(8'd3, 8'h00, "R1 deselected read returns zero");
    chk("R1 deselected read keeps interrupt", {7'd0, int_n}, 8'd0);
    tick(3);
    chk("R1 deselected write keeps mode", {7'd0, lowp}, 8'd1);
    sel_n = 1'b0;
    tick(5);
    reg_read(8'd93, 8'h00, "R1 deselected write ignored");
    reg_read(8'd3, 8'h01, "R1 flag kept while deselected");
    tick(2);
    finished = 1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule